// File: doc/BRIEF.md
# External Bus Strobe Generator

This block takes one internal access request and turns it into the control strobes that an external asynchronous memory expects. Those strobes are an active-low read strobe, write strobes, a byte-high-enable line, and a word address whose bit 0 carries byte-lane meaning. Each accepted request runs a fixed sequence. First comes one clock of address setup with all strobes inactive. Then the strobe is active for one clock plus a programmable number of wait clocks. Last comes one clock of hold with strobes inactive. A one-clock done pulse marks the hold clock.

There are two strobe styles. In the shared style, one write strobe is used and the byte lanes are coded on the byte-high-enable line together with address bit 0. In the split style, the low byte and the high byte each have their own write strobe. A configuration register selects the style and the wait count. Reset selects the shared style. Two cases always use the shared style, whatever the register holds: an access marked as targeting an 8-bit space, and any access while the external bus is strapped 8 bits wide. The configuration is sampled when a request is accepted, so a register write made during a bus cycle applies from the next request onward.

Top module: `ext_strobe_gen`

## Requirements
- R1: After reset the block is idle. Outputs are: `ready`=1, `done`=0, `rd_n`, `wrlo_n`, `wrhi_n` and `bhe_n` all 1, and `ext_addr`=0. The configuration holds the shared style with 0 wait clocks.
- R2: A request presented with `req_valid`=1 while `ready`=1 is accepted at that clock edge. The next clock is setup, with all strobes high and `ready`=0. Then come 1+W strobe clocks, where W is the wait count sampled at acceptance. Then comes 1 hold clock with all strobes high and `done`=1. `ready` returns to 1 on the clock after hold.
- R3: A read (`req_write`=0) drives `rd_n`=0 during the strobe clocks only, and `wrlo_n`=`wrhi_n`=1 throughout. A write never drives `rd_n` low.
- R4: In shared style on a 16-bit bus, the lane code is taken from `req_be` (bit 0 is the even byte, bit 1 the odd byte). For both reads and writes, `bhe_n`/`ext_addr[0]` are held through setup, strobe and hold as follows: even byte gives 1/0, odd byte gives 0/1, both bytes gives 0/0. `req_be`=00 is treated as both bytes.
- R5: In shared style a write drives `wrlo_n`=0 as the single write strobe during the strobe clocks. `wrhi_n` stays 1.
- R6: In split style on a 16-bit bus, a write drives `wrlo_n`=~be[0] and `wrhi_n`=~be[1] during the strobe clocks, with be=00 treated as 11. `bhe_n`=1 and `ext_addr[0]`=0 hold for the whole cycle.
- R7: When `req_narrow`=1 or `bus16`=0, shared style is forced. `ext_addr[0]` follows `req_addr[0]`, while `bhe_n`=1 and `wrhi_n`=1 hold for the whole cycle.
- R8: Writing `cfg_split`/`cfg_wait` through `cfg_we` during a bus cycle does not change that cycle. The new values apply from the next accepted request.
- R9: A request presented while `ready`=0 is ignored and is not run later.
- R10: `ext_addr[ADDR_W-1:1]` equals `req_addr[ADDR_W-1:1]` of the accepted request, held stable from setup through hold.
- R11: The number of strobe clocks equals 1 plus the programmed wait count (0 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus16 | input | 1 | External bus strap: 1 = 16-bit, 0 = 8-bit |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_split | input | 1 | Style bit to write: 1 = split write strobes |
| cfg_wait | input | WAIT_W | Wait-clock count to write |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_be | input | 2 | Byte enables: bit 0 even byte, bit 1 odd byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_narrow | input | 1 | Access targets an 8-bit space |
| ready | output | 1 | Idle, can accept a request |
| done | output | 1 | One-clock pulse during the hold clock |
| rd_n | output | 1 | Read strobe, active low |
| wrlo_n | output | 1 | Shared write strobe, or low-byte write strobe in split style |
| wrhi_n | output | 1 | High-byte write strobe (split style only) |
| bhe_n | output | 1 | Byte-high enable, active low |
| ext_addr | output | ADDR_W | External address; bit 0 carries lane coding |

## Verification
Reads and writes are run for each byte-enable value in the shared style, and then again in the split style. This shows that the lane code moves between `bhe_n`/`ext_addr[0]` and the two write strobes depending on the style. The same odd-byte write is repeated in three settings: with the narrow flag set, with the bus strapped 8 bits wide, and with the split style selected. This separates the forced fallback from the register setting. Several wait counts are used, which exposes off-by-one errors in strobe length. One cycle has a configuration write and a second request injected in its middle. This tells apart sampling the configuration at acceptance from sampling it live, and checks that a request arriving while busy is dropped.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // attributes of one accepted access, frozen for its whole cycle
    typedef struct packed {
        logic       write;
        logic       narrow;
        logic [1:0] be;
        logic       split;
        logic       bus16;
    } access_t;

    // external control lines plus the lane-coded address bit
    typedef struct packed {
        logic rd_n;
        logic wrlo_n;
        logic wrhi_n;
        logic bhe_n;
        logic a0;
    } lanes_t;

endpackage

// File: rtl/ebs_mode_reg.sv
module ebs_mode_reg #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_split,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              split_q,
    output logic [WAIT_W-1:0] wait_q
);

    typedef struct packed {
        logic              split;
        logic [WAIT_W-1:0] waits;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (cfg_we) begin
            mode_d.split = cfg_split;
            mode_d.waits = cfg_wait;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign split_q = mode_q.split;
    assign wait_q  = mode_q.waits;

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(mode_q)) else $error("mode changed without write"); // R8

endmodule

// File: rtl/ebs_seq.sv
module ebs_seq
    import ebs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic              req_write,
    input  logic              req_narrow,
    input  logic              bus16,
    input  logic              split_q,
    input  logic [WAIT_W-1:0] wait_q,
    output phase_e            phase,
    output access_t           acc,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              done
);

    typedef struct packed {
        phase_e            ph;
        logic [WAIT_W-1:0] cnt;
        logic [WAIT_W-1:0] waits;
        access_t           acc;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.ph         = PH_SETUP;
                    s_d.addr       = req_addr;
                    s_d.waits      = wait_q;
                    s_d.acc.write  = req_write;
                    s_d.acc.narrow = req_narrow;
                    s_d.acc.be     = req_be;
                    s_d.acc.split  = split_q;
                    s_d.acc.bus16  = bus16;
                end
            end
            PH_SETUP: begin
                s_d.ph  = PH_STROBE;
                s_d.cnt = s_q.waits;
            end
            PH_STROBE: begin
                if (s_q.cnt == '0) begin
                    s_d.ph = PH_HOLD;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                s_d.ph = PH_IDLE;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.ph;
    assign acc   = s_q.acc;
    assign addr  = s_q.addr;
    assign ready = (s_q.ph == PH_IDLE);
    assign done  = (s_q.ph == PH_HOLD);

    AST_SETUP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> (phase == PH_SETUP)) else $error("no setup"); // R2
    AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP) |=> (phase == PH_STROBE)) else $error("no strobe"); // R2
    AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !done) |=> ($stable(acc) && $stable(addr))) else $error("latched access moved"); // R8

endmodule

// File: rtl/ebs_lane_decode.sv
module ebs_lane_decode
    import ebs_pkg::*;
(
    input  phase_e  phase,
    input  access_t acc,
    input  logic    addr0,
    output lanes_t  lanes
);

    logic       byte_mode;
    logic       split_eff;
    logic [1:0] be_w;
    logic       active;

    always_comb begin
        byte_mode = acc.narrow | ~acc.bus16;
        split_eff = acc.split & ~byte_mode;
        be_w      = (acc.be == 2'b00) ? 2'b11 : acc.be;
        active    = (phase == PH_STROBE);

        lanes = '{rd_n: 1'b1, wrlo_n: 1'b1, wrhi_n: 1'b1, bhe_n: 1'b1, a0: 1'b0};

        if (phase != PH_IDLE) begin
            if (byte_mode) begin
                lanes.a0 = addr0;
            end else if (!split_eff) begin
                lanes.bhe_n = ~be_w[1];
                lanes.a0    = (be_w == 2'b10);
            end
            if (active) begin
                if (!acc.write) begin
                    lanes.rd_n = 1'b0;
                end else if (split_eff) begin
                    lanes.wrlo_n = ~be_w[0];
                    lanes.wrhi_n = ~be_w[1];
                end else begin
                    lanes.wrlo_n = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/ext_strobe_gen.sv
module ext_strobe_gen
    import ebs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus16,
    input  logic              cfg_we,
    input  logic              cfg_split,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic              req_write,
    input  logic              req_narrow,
    output logic              ready,
    output logic              done,
    output logic              rd_n,
    output logic              wrlo_n,
    output logic              wrhi_n,
    output logic              bhe_n,
    output logic [ADDR_W-1:0] ext_addr
);

    logic              split_q;
    logic [WAIT_W-1:0] wait_q;
    phase_e            phase;
    access_t           acc;
    logic [ADDR_W-1:0] addr_q;
    lanes_t            lanes;

    ebs_mode_reg #(.WAIT_W(WAIT_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_split (cfg_split),
        .cfg_wait  (cfg_wait),
        .split_q   (split_q),
        .wait_q    (wait_q)
    );

    ebs_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_write  (req_write),
        .req_narrow (req_narrow),
        .bus16      (bus16),
        .split_q    (split_q),
        .wait_q     (wait_q),
        .phase      (phase),
        .acc        (acc),
        .addr       (addr_q),
        .ready      (ready),
        .done       (done)
    );

    ebs_lane_decode u_dec (
        .phase (phase),
        .acc   (acc),
        .addr0 (addr_q[0]),
        .lanes (lanes)
    );

    assign rd_n     = lanes.rd_n;
    assign wrlo_n   = lanes.wrlo_n;
    assign wrhi_n   = lanes.wrhi_n;
    assign bhe_n    = lanes.bhe_n;
    assign ext_addr = (phase == PH_IDLE) ? '0 : {addr_q[ADDR_W-1:1], lanes.a0};

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (rd_n && wrlo_n && wrhi_n && bhe_n && !done)) else $error("idle strobe"); // R1
    AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> (rd_n && wrlo_n && wrhi_n && !ready)) else $error("setup strobe"); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ready && !done)) else $error("done not a pulse"); // R2
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && (!wrlo_n || !wrhi_n))) else $error("read and write together"); // R3
    AST_NARROW_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && (acc.narrow || !acc.bus16)) |-> (wrhi_n && bhe_n)) else $error("narrow used high lane"); // R7
    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !done) |=> !ready) else $error("busy cycle broken"); // R9
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !done) |=> $stable(ext_addr[ADDR_W-1:1])) else $error("address moved"); // R10

endmodule

// File: tb/ext_strobe_gen_tb.sv
`timescale 1ns/1ps
module ext_strobe_gen_tb;

    localparam int AW = 16;
    localparam int WW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus16 = 1'b1;
    logic          cfg_we = 1'b0;
    logic          cfg_split = 1'b0;
    logic [WW-1:0] cfg_wait = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_be = '0;
    logic          req_write = 1'b0;
    logic          req_narrow = 1'b0;
    logic          ready, done, rd_n, wrlo_n, wrhi_n, bhe_n;
    logic [AW-1:0] ext_addr;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    bit m_split = 0;
    int m_wait  = 0;

    always #2.5 clk = ~clk;

    ext_strobe_gen #(.ADDR_W(AW), .WAIT_W(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus16(bus16),
        .cfg_we(cfg_we), .cfg_split(cfg_split), .cfg_wait(cfg_wait),
        .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
        .req_write(req_write), .req_narrow(req_narrow),
        .ready(ready), .done(done), .rd_n(rd_n), .wrlo_n(wrlo_n),
        .wrhi_n(wrhi_n), .bhe_n(bhe_n), .ext_addr(ext_addr)
    );

    // expected {rd_n, wrlo_n, wrhi_n, bhe_n, a0} from the requirement text
    function automatic logic [4:0] exp_lanes(bit wr, bit [1:0] be, bit nar, bit adr0,
                                             bit spl, bit b16, bit strobe);
        bit rd = 1, wl = 1, wh = 1, bh = 1, a = 0;
        bit lo_on = (be == 2'b00) || be[0];
        bit hi_on = (be == 2'b00) || be[1];
        if (nar || !b16) begin                 // R7
            a = adr0;
            if (strobe && wr) wl = 0;
        end else if (spl) begin                // R6
            if (strobe && wr) begin
                wl = !lo_on;
                wh = !hi_on;
            end
        end else begin                         // R4 / R5
            if (lo_on && hi_on) begin bh = 0; a = 0; end
            else if (hi_on)     begin bh = 0; a = 1; end
            else                begin bh = 1; a = 0; end
            if (strobe && wr) wl = 0;
        end
        if (strobe && !wr) rd = 0;             // R3
        return {rd, wl, wh, bh, a};
    endfunction

    task automatic check(string tag, logic [AW+5:0] exp);
        logic [AW+5:0] act = {ready, done, rd_n, wrlo_n, wrhi_n, bhe_n, ext_addr};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_idle(string tag);
        check(tag, {1'b1, 1'b0, 4'b1111, {AW{1'b0}}});
    endtask

    task automatic set_cfg(bit spl, int w);
        cfg_we = 1; cfg_split = spl; cfg_wait = WW'(w);
        @(negedge clk);
        cfg_we = 0;
        m_split = spl; m_wait = w;
    endtask

    // one access, compared on every clock; poke injects a config write and a
    // stray request during the strobe phase
    task automatic access(logic [AW-1:0] a, logic [1:0] be, bit wr, bit nar,
                          string tag, bit poke, bit p_split, int p_wait);
        bit l_split = m_split;
        int l_wait  = m_wait;
        bit l_b16   = bus16;
        int total   = 3 + l_wait;
        logic [4:0] ln;
        req_valid = 1; req_addr = a; req_be = be; req_write = wr; req_narrow = nar;
        @(negedge clk);
        req_valid = 0; req_addr = '0; req_be = '0; req_write = 0; req_narrow = 0;
        for (int c = 0; c < total; c++) begin
            if (c > 0) @(negedge clk);
            if (poke && c == 2) begin
                cfg_we = 0; req_valid = 0;
                m_split = p_split; m_wait = p_wait;
            end
            ln = exp_lanes(wr, be, nar, a[0], l_split, l_b16, (c > 0 && c < total - 1));
            check(tag, {1'b0, (c == total - 1), ln[4:1], a[AW-1:1], ln[0]});
            if (poke && c == 1) begin
                cfg_we = 1; cfg_split = p_split; cfg_wait = WW'(p_wait);
                req_valid = 1; req_addr = 16'h5A5B; req_be = 2'b11; req_write = 1;
            end
        end
        @(negedge clk);
        check_idle({tag, " idle R2 R9"});
    endtask

    initial begin : watchdog
        #(5ns * 20000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_idle("R1 reset idle");

        // shared style, 16-bit bus, no waits
        access(16'h1234, 2'b01, 1'b1, 0, "R4 R5 shared even wr", 0, 0, 0);
        access(16'h1235, 2'b10, 1'b1, 0, "R4 R5 shared odd wr", 0, 0, 0);
        access(16'h2000, 2'b11, 1'b1, 0, "R4 R5 shared word wr", 0, 0, 0);
        access(16'h2002, 2'b00, 1'b1, 0, "R4 shared be00 wr", 0, 0, 0);
        access(16'h3001, 2'b10, 1'b0, 0, "R3 R4 shared odd rd", 0, 0, 0);
        access(16'h3000, 2'b01, 1'b0, 0, "R3 R4 shared even rd", 0, 0, 0);
        access(16'h3ffe, 2'b11, 1'b0, 0, "R3 R4 R10 shared word rd", 0, 0, 0);

        // wait counts
        set_cfg(0, 2);
        access(16'hABCD, 2'b11, 1'b0, 0, "R11 wait2 rd", 0, 0, 0);
        set_cfg(0, 3);
        access(16'h8001, 2'b10, 1'b1, 0, "R11 wait3 wr", 0, 0, 0);

        // split style
        set_cfg(1, 1);
        access(16'h4000, 2'b01, 1'b1, 0, "R6 split even wr", 0, 0, 0);
        access(16'h4001, 2'b10, 1'b1, 0, "R6 split odd wr", 0, 0, 0);
        access(16'h4002, 2'b11, 1'b1, 0, "R6 split word wr", 0, 0, 0);
        access(16'h4004, 2'b00, 1'b1, 0, "R6 split be00 wr", 0, 0, 0);
        access(16'h4006, 2'b11, 1'b0, 0, "R3 R6 split rd", 0, 0, 0);

        // forced fallback
        access(16'h5003, 2'b10, 1'b1, 1, "R7 narrow over split wr", 0, 0, 0);
        access(16'h5005, 2'b10, 1'b0, 1, "R7 narrow rd", 0, 0, 0);
        bus16 = 0;
        access(16'h6007, 2'b10, 1'b1, 0, "R7 8bit bus wr", 0, 0, 0);
        access(16'h6006, 2'b01, 1'b0, 0, "R7 8bit bus rd", 0, 0, 0);
        bus16 = 1;

        // config write and stray request mid-cycle
        set_cfg(0, 0);
        access(16'h7001, 2'b10, 1'b1, 0, "R8 R9 mid cfg write", 1, 1, 2);
        access(16'h7003, 2'b10, 1'b1, 0, "R8 next uses split", 0, 0, 0);
        access(16'h7004, 2'b11, 1'b1, 0, "R8 R11 next wait2", 1, 0, 0);
        access(16'h7005, 2'b10, 1'b0, 0, "R8 back to shared", 0, 0, 0);

        repeat (2) @(negedge clk);
        check_idle("R1 R9 final idle");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule